// File: doc/BRIEF.md
# SPI Master Channel Interrupt Event Generator

This block raises the interrupt events of one SPI master channel: transmit-empty, transmit-underflow, receive-full and end-of-word-count. It observes the channel enable, the receive-only mode, the channel's transmit and receive FIFO requests, the CPU's single-byte write and read strobes to the data registers, and two strobes from the serial engine. The first strobe marks the shifter taking the next word for transmission. The second marks a received word landing. The block keeps its own occupancy counts for the transmit register or FIFO and for the receive register or FIFO. Data storage, the shifter and the bus fabric are not part of it.

With a FIFO in use, the transmit and receive events follow a threshold handshake. An event fires once when its threshold is met. It fires again only after the CPU has made as many accesses as the programmed level. Each event sets a sticky status bit that software clears by writing one. A masked OR of those bits drives the interrupt line. When the programmed transfer count completes, the block raises a halt request to the serial engine. That request holds until the channel is disabled.

Top module: `spi_irq_gen`

## Requirements
- R1: After reset, `status`, `irq` and `halt` are all zero.
- R2: With the transmit FIFO not in use, the transmit-empty event (status bit 0) fires when the channel becomes enabled. It also fires when `shift_load` empties a transmit register that holds data. It never fires while `rx_only` is high.
- R3: With the transmit FIFO in use, an armed channel fires transmit-empty as soon as the free byte count (DEPTH minus occupancy) is at least `ae_level`. Enabling the channel arms it.
- R4: After a transmit FIFO event, the channel re-arms only once the CPU has made `ae_level` writes. Until then no transmit-empty event fires, whatever the free space.
- R5: Transmit-underflow (status bit 1) fires when `shift_load` arrives while the transmit register or FIFO holds no unsent data. It is suppressed until the first CPU write since the channel was enabled.
- R6: With the receive FIFO not in use, receive-full (status bit 2) fires when `rx_word_done` fills an empty receive register. A word that lands while the register is still full raises no event.
- R7: With the receive FIFO in use, an armed channel fires receive-full when the occupancy equals `af_level`. After the event, the channel re-arms only once the CPU has made `af_level` reads.
- R8: With a FIFO in use and a nonzero `word_count`, end-of-word-count (status bit 3) fires on the `word_count`-th `shift_load` since enable. `halt` rises in the same cycle and stays high until `chan_en` falls. A `word_count` of zero raises neither.
- R9: When `other_fifo_req` is high, the FIFO is bypassed. Both transmit and receive then behave as in the non-FIFO mode, and end-of-word-count never fires.
- R10: Status bits are sticky. Writing a one to a bit of `sts_clr` clears that bit. An event in the same cycle as the clear wins, so the bit stays set.
- R11: `irq` is high exactly when some status bit is set and its bit in `irq_mask` is one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chan_en | input | 1 | Channel enable; low clears all channel state |
| rx_only | input | 1 | Receive-only mode, suppresses transmit-empty |
| tx_fifo_en | input | 1 | This channel requests the FIFO for transmit |
| rx_fifo_en | input | 1 | This channel requests the FIFO for receive |
| other_fifo_req | input | 1 | Another enabled channel also requests the FIFO |
| ae_level | input | CW | Transmit almost-empty level in bytes, 1 to DEPTH |
| af_level | input | CW | Receive almost-full level in bytes, 1 to DEPTH |
| word_count | input | WCW | Transfers before end-of-word-count, 0 disables |
| cpu_tx_wr | input | 1 | CPU write of one byte to transmit data |
| cpu_rx_rd | input | 1 | CPU read of one byte from receive data |
| shift_load | input | 1 | Shifter takes the next transmit word |
| rx_word_done | input | 1 | A received word lands in the receive register or FIFO |
| sts_clr | input | 4 | Write-one-to-clear strobes for the status bits |
| irq_mask | input | 4 | Per-event interrupt enables |
| status | output | 4 | Sticky event bits: 0 tx-empty, 1 underflow, 2 rx-full, 3 end-of-word-count |
| irq | output | 1 | Masked interrupt line |
| halt | output | 1 | Transfer halt request after the word count completes |

## Verification
The hardest case to reach from the ports is a FIFO level that equals its threshold while the channel is still disarmed. The threshold condition is then true, but the access handshake is incomplete. For every level from 1 to the bench depth, the stimulus first drains the receive FIFO by one fewer read than the level, then refills it to exactly the level, and the bench expects no event. A single further read completes the handshake, and one more word must fire. On the transmit side, the sweep writes exactly the level and then pops words back. Whether the event fires on the write or on the later pops depends on whether twice the level fits in the depth, and the bench computes that expectation arithmetically.

// File: rtl/spi_irq_pkg.sv
package spi_irq_pkg;

    localparam int NUM_EV = 4;
    localparam int EV_TXE = 0;
    localparam int EV_UF  = 1;
    localparam int EV_RXF = 2;
    localparam int EV_EOW = 3;

    typedef struct packed {
        logic eow;
        logic rxf;
        logic uf;
        logic txe;
    } ev_vec_t;

    function automatic int cnt_width(input int depth);
        return $clog2(depth + 1);
    endfunction

endpackage

// File: rtl/spi_irq_tx_unit.sv
module spi_irq_tx_unit #(
    parameter int DEPTH = 32,
    parameter int CW    = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          chan_en,
    input  logic          rx_only,
    input  logic          fifo_on,
    input  logic          cpu_wr,
    input  logic          shift_load,
    input  logic [CW-1:0] ae_level,
    output logic          txe_ev,
    output logic          uf_ev
);
    localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);
    localparam logic [CW-1:0] ONE_C   = CW'(1);

    logic [CW-1:0] occ;
    logic [CW-1:0] wr_tally;
    logic          armed;
    logic          hold_full;
    logic          en_q;
    logic          wrote;
    logic          fresh;
    logic [CW-1:0] free_b;

    always_comb begin
        free_b = DEPTH_C - occ;
        fresh  = fifo_on ? (occ != '0) : hold_full;
        uf_ev  = chan_en & shift_load & wrote & ~fresh;
        if (fifo_on) begin
            txe_ev = chan_en & ~rx_only & armed & (free_b >= ae_level);
        end else begin
            txe_ev = chan_en & ~rx_only & (~en_q | (shift_load & hold_full));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q <= 1'b0;
        end else begin
            en_q <= chan_en;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !chan_en) begin
            occ       <= '0;
            wr_tally  <= '0;
            armed     <= 1'b1;
            hold_full <= 1'b0;
            wrote     <= 1'b0;
        end else begin
            wrote <= wrote | cpu_wr;
            if (cpu_wr) begin
                hold_full <= 1'b1;
            end else if (shift_load) begin
                hold_full <= 1'b0;
            end
            if (!fifo_on) begin
                occ      <= '0;
                wr_tally <= '0;
                armed    <= 1'b1;
            end else begin
                if (cpu_wr && (occ != DEPTH_C) && !(shift_load && occ != '0)) begin
                    occ <= occ + ONE_C;
                end else if (!(cpu_wr && occ != DEPTH_C) && shift_load && occ != '0) begin
                    occ <= occ - ONE_C;
                end
                if (txe_ev) begin
                    armed    <= 1'b0;
                    wr_tally <= '0;
                end else if (!armed && cpu_wr) begin
                    if ((wr_tally + ONE_C) >= ae_level) begin
                        armed    <= 1'b1;
                        wr_tally <= '0;
                    end else begin
                        wr_tally <= wr_tally + ONE_C;
                    end
                end
            end
        end
    end

endmodule

// File: rtl/spi_irq_rx_unit.sv
module spi_irq_rx_unit #(
    parameter int DEPTH = 32,
    parameter int CW    = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          chan_en,
    input  logic          fifo_on,
    input  logic          cpu_rd,
    input  logic          word_done,
    input  logic [CW-1:0] af_level,
    output logic          rxf_ev
);
    localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);
    localparam logic [CW-1:0] ONE_C   = CW'(1);

    logic [CW-1:0] occ;
    logic [CW-1:0] rd_tally;
    logic          armed;
    logic          hold_full;
    logic          push;
    logic          pop;

    always_comb begin
        push = word_done & (occ != DEPTH_C);
        pop  = cpu_rd & (occ != '0);
        if (fifo_on) begin
            rxf_ev = chan_en & armed & (occ == af_level);
        end else begin
            rxf_ev = chan_en & word_done & ~hold_full;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !chan_en) begin
            occ       <= '0;
            rd_tally  <= '0;
            armed     <= 1'b1;
            hold_full <= 1'b0;
        end else begin
            if (word_done) begin
                hold_full <= 1'b1;
            end else if (cpu_rd) begin
                hold_full <= 1'b0;
            end
            if (!fifo_on) begin
                occ      <= '0;
                rd_tally <= '0;
                armed    <= 1'b1;
            end else begin
                if (push && !pop) begin
                    occ <= occ + ONE_C;
                end else if (pop && !push) begin
                    occ <= occ - ONE_C;
                end
                if (rxf_ev) begin
                    armed    <= 1'b0;
                    rd_tally <= '0;
                end else if (!armed && cpu_rd) begin
                    if ((rd_tally + ONE_C) >= af_level) begin
                        armed    <= 1'b1;
                        rd_tally <= '0;
                    end else begin
                        rd_tally <= rd_tally + ONE_C;
                    end
                end
            end
        end
    end

endmodule

// File: rtl/spi_irq_eow_unit.sv
module spi_irq_eow_unit #(
    parameter int WCW = 16
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           chan_en,
    input  logic           fifo_use,
    input  logic           shift_load,
    input  logic [WCW-1:0] word_count,
    output logic           eow_ev,
    output logic           halt
);
    localparam logic [WCW-1:0] ONE_W = WCW'(1);

    logic [WCW-1:0] xfer;
    logic           counting;

    always_comb begin
        counting = chan_en & fifo_use & (word_count != '0) & ~halt & shift_load;
        eow_ev   = counting & (xfer == (word_count - ONE_W));
    end

    always_ff @(posedge clk) begin
        if (rst || !chan_en) begin
            xfer <= '0;
            halt <= 1'b0;
        end else if (eow_ev) begin
            xfer <= '0;
            halt <= 1'b1;
        end else if (counting) begin
            xfer <= xfer + ONE_W;
        end
    end

endmodule

// File: rtl/spi_irq_status.sv
module spi_irq_status #(
    parameter int NEV = 4
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [NEV-1:0] ev,
    input  logic [NEV-1:0] clr,
    input  logic [NEV-1:0] mask,
    output logic [NEV-1:0] status,
    output logic           irq
);
    always_ff @(posedge clk) begin
        if (rst) begin
            status <= '0;
        end else begin
            status <= (status & ~clr) | ev;
        end
    end

    always_comb begin
        irq = |(status & mask);
    end

endmodule

// File: rtl/spi_irq_gen.sv
module spi_irq_gen
    import spi_irq_pkg::*;
#(
    parameter int   DEPTH = 32,
    parameter int   WCW   = 16,
    localparam int  CW    = cnt_width(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              chan_en,
    input  logic              rx_only,
    input  logic              tx_fifo_en,
    input  logic              rx_fifo_en,
    input  logic              other_fifo_req,
    input  logic [CW-1:0]     ae_level,
    input  logic [CW-1:0]     af_level,
    input  logic [WCW-1:0]    word_count,
    input  logic              cpu_tx_wr,
    input  logic              cpu_rx_rd,
    input  logic              shift_load,
    input  logic              rx_word_done,
    input  logic [NUM_EV-1:0] sts_clr,
    input  logic [NUM_EV-1:0] irq_mask,
    output logic [NUM_EV-1:0] status,
    output logic              irq,
    output logic              halt
);
    logic    fifo_use;
    logic    tx_fifo_on;
    logic    rx_fifo_on;
    ev_vec_t evs;

    always_comb begin
        fifo_use   = (tx_fifo_en | rx_fifo_en) & ~other_fifo_req;
        tx_fifo_on = fifo_use & tx_fifo_en;
        rx_fifo_on = fifo_use & rx_fifo_en;
    end

    spi_irq_tx_unit #(.DEPTH(DEPTH), .CW(CW)) tx_u (
        .clk        (clk),
        .rst        (rst),
        .chan_en    (chan_en),
        .rx_only    (rx_only),
        .fifo_on    (tx_fifo_on),
        .cpu_wr     (cpu_tx_wr),
        .shift_load (shift_load),
        .ae_level   (ae_level),
        .txe_ev     (evs.txe),
        .uf_ev      (evs.uf)
    );

    spi_irq_rx_unit #(.DEPTH(DEPTH), .CW(CW)) rx_u (
        .clk       (clk),
        .rst       (rst),
        .chan_en   (chan_en),
        .fifo_on   (rx_fifo_on),
        .cpu_rd    (cpu_rx_rd),
        .word_done (rx_word_done),
        .af_level  (af_level),
        .rxf_ev    (evs.rxf)
    );

    spi_irq_eow_unit #(.WCW(WCW)) eow_u (
        .clk        (clk),
        .rst        (rst),
        .chan_en    (chan_en),
        .fifo_use   (fifo_use),
        .shift_load (shift_load),
        .word_count (word_count),
        .eow_ev     (evs.eow),
        .halt       (halt)
    );

    spi_irq_status #(.NEV(NUM_EV)) sts_u (
        .clk    (clk),
        .rst    (rst),
        .ev     (evs),
        .clr    (sts_clr),
        .mask   (irq_mask),
        .status (status),
        .irq    (irq)
    );

endmodule

// File: rtl/spi_irq_chk.sv
module spi_irq_chk #(
    parameter int WCW = 16
) (
    input logic           clk,
    input logic           rst,
    input logic           chan_en,
    input logic           rx_only,
    input logic           tx_fifo_en,
    input logic           rx_fifo_en,
    input logic           other_fifo_req,
    input logic [WCW-1:0] word_count,
    input logic           cpu_tx_wr,
    input logic [3:0]     sts_clr,
    input logic [3:0]     irq_mask,
    input logic [3:0]     status,
    input logic           irq,
    input logic           halt
);
    logic wr_seen;

    always_ff @(posedge clk) begin
        if (rst || !chan_en) begin
            wr_seen <= 1'b0;
        end else if (cpu_tx_wr) begin
            wr_seen <= 1'b1;
        end
    end

    // R2
    txe_quiet_rx_only_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(status[0]) |-> !$past(rx_only));

    // R5
    uf_after_write_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(status[1]) |-> $past(wr_seen));

    // R8
    eow_needs_count_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(status[3]) |-> $past((word_count != '0) && (tx_fifo_en || rx_fifo_en) && !other_fifo_req));

    // R8
    halt_with_eow_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(halt) |-> status[3]);

    // R8
    halt_until_disable_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(halt) |-> !$past(chan_en));

    // R10
    sticky_bits_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((($past(status) & ~$past(sts_clr)) & ~status) == 4'b0000));

    // R11
    masked_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (irq_mask == 4'b0000) |-> !irq);

endmodule

bind spi_irq_gen spi_irq_chk #(.WCW(WCW)) chk_i (
    .clk            (clk),
    .rst            (rst),
    .chan_en        (chan_en),
    .rx_only        (rx_only),
    .tx_fifo_en     (tx_fifo_en),
    .rx_fifo_en     (rx_fifo_en),
    .other_fifo_req (other_fifo_req),
    .word_count     (word_count),
    .cpu_tx_wr      (cpu_tx_wr),
    .sts_clr        (sts_clr),
    .irq_mask       (irq_mask),
    .status         (status),
    .irq            (irq),
    .halt           (halt)
);

// File: tb/spi_irq_gen_tb.sv
module spi_irq_gen_tb_top;
    localparam int CLK_P = 10;
    localparam int DEPTH = 8;
    localparam int WCW   = 8;
    localparam int CW    = $clog2(DEPTH + 1);

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           chan_en = 1'b0;
    logic           rx_only = 1'b0;
    logic           tx_fifo_en = 1'b0;
    logic           rx_fifo_en = 1'b0;
    logic           other_fifo_req = 1'b0;
    logic [CW-1:0]  ae_level = CW'(1);
    logic [CW-1:0]  af_level = CW'(1);
    logic [WCW-1:0] word_count = '0;
    logic           cpu_tx_wr = 1'b0;
    logic           cpu_rx_rd = 1'b0;
    logic           shift_load = 1'b0;
    logic           rx_word_done = 1'b0;
    logic [3:0]     sts_clr = 4'h0;
    logic [3:0]     irq_mask = 4'h0;
    logic [3:0]     status;
    logic           irq;
    logic           halt;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    spi_irq_gen #(.DEPTH(DEPTH), .WCW(WCW)) dut_i (
        .clk(clk), .rst(rst), .chan_en(chan_en), .rx_only(rx_only),
        .tx_fifo_en(tx_fifo_en), .rx_fifo_en(rx_fifo_en),
        .other_fifo_req(other_fifo_req), .ae_level(ae_level),
        .af_level(af_level), .word_count(word_count),
        .cpu_tx_wr(cpu_tx_wr), .cpu_rx_rd(cpu_rx_rd),
        .shift_load(shift_load), .rx_word_done(rx_word_done),
        .sts_clr(sts_clr), .irq_mask(irq_mask),
        .status(status), .irq(irq), .halt(halt)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic settle();
        tick();
        tick();
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr_n(input int n);
        for (int i = 0; i < n; i++) begin
            cpu_tx_wr = 1'b1; tick(); cpu_tx_wr = 1'b0;
        end
    endtask

    task automatic rd_n(input int n);
        for (int i = 0; i < n; i++) begin
            cpu_rx_rd = 1'b1; tick(); cpu_rx_rd = 1'b0;
        end
    endtask

    task automatic load_n(input int n);
        for (int i = 0; i < n; i++) begin
            shift_load = 1'b1; tick(); shift_load = 1'b0;
        end
    endtask

    task automatic land_n(input int n);
        for (int i = 0; i < n; i++) begin
            rx_word_done = 1'b1; tick(); rx_word_done = 1'b0;
        end
    endtask

    task automatic clear_all();
        sts_clr = 4'hF; tick(); sts_clr = 4'h0; tick();
    endtask

    task automatic enable_ch();
        chan_en = 1'b1; settle();
    endtask

    task automatic disable_ch();
        chan_en = 1'b0; settle();
    endtask

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        settle();
        rst = 1'b0;
        tick();
        // R1 reset state
        chk("R1 status", 32'(status), 32'h0);
        chk("R1 irq", 32'(irq), 32'h0);
        chk("R1 halt", 32'(halt), 32'h0);

        // R2 non-FIFO transmit-empty
        enable_ch();
        chk("R2 enable", 32'(status[0]), 32'h1);
        clear_all();
        wr_n(1); settle();
        chk("R2 loaded", 32'(status[0]), 32'h0);
        load_n(1); settle();
        chk("R2 emptied", 32'(status[0]), 32'h1);
        chk("R5 fresh load", 32'(status[1]), 32'h0);
        clear_all();
        load_n(1); settle();
        chk("R5 underflow", 32'(status[1]), 32'h1);
        disable_ch();
        enable_ch(); clear_all();
        load_n(2); settle();
        chk("R5 no write since enable", 32'(status[1]), 32'h0);
        disable_ch(); clear_all();
        rx_only = 1'b1;
        enable_ch();
        chk("R2 rx_only", 32'(status[0]), 32'h0);
        disable_ch();
        rx_only = 1'b0;

        // R6 non-FIFO receive-full
        enable_ch(); clear_all();
        land_n(1); settle();
        chk("R6 filled", 32'(status[2]), 32'h1);
        clear_all();
        land_n(1); settle();
        chk("R6 still full", 32'(status[2]), 32'h0);
        rd_n(1); land_n(1); settle();
        chk("R6 refilled", 32'(status[2]), 32'h1);
        disable_ch(); clear_all();

        // R10 R11 sticky clear and mask
        enable_ch();
        irq_mask = 4'h0; tick();
        chk("R11 mask none", 32'(irq), 32'h0);
        irq_mask = 4'h1; tick();
        chk("R11 mask txe", 32'(irq), 32'h1);
        irq_mask = 4'hE; tick();
        chk("R11 mask others", 32'(irq), 32'h0);
        tick();
        chk("R10 sticky", 32'(status[0]), 32'h1);
        sts_clr = 4'h1; tick(); sts_clr = 4'h0; tick();
        chk("R10 cleared", 32'(status[0]), 32'h0);
        disable_ch(); clear_all();
        chan_en = 1'b1; sts_clr = 4'h1; tick(); sts_clr = 4'h0; tick();
        chk("R10 set wins", 32'(status[0]), 32'h1);
        disable_ch(); clear_all();
        irq_mask = 4'h0;

        // R3 R4 transmit FIFO threshold sweep
        tx_fifo_en = 1'b1;
        for (int ae = 1; ae <= DEPTH; ae++) begin
            ae_level = CW'(ae);
            enable_ch();
            chk("R3 armed at enable", 32'(status[0]), 32'h1);
            clear_all();
            wr_n(ae - 1); settle();
            chk("R4 before handshake", 32'(status[0]), 32'h0);
            wr_n(1); settle();
            chk("R3 after handshake", 32'(status[0]), ((DEPTH - ae) >= ae) ? 32'h1 : 32'h0);
            clear_all();
            load_n(ae); settle();
            chk("R4 after drain", 32'(status[0]), ((DEPTH - ae) >= ae) ? 32'h0 : 32'h1);
            disable_ch(); clear_all();
        end
        tx_fifo_en = 1'b0;

        // R7 receive FIFO threshold sweep
        rx_fifo_en = 1'b1;
        for (int af = 1; af <= DEPTH; af++) begin
            af_level = CW'(af);
            enable_ch(); clear_all();
            land_n(af - 1); settle();
            chk("R7 below level", 32'(status[2]), 32'h0);
            land_n(1); settle();
            chk("R7 at level", 32'(status[2]), 32'h1);
            clear_all();
            rd_n(af - 1); land_n(af - 1); settle();
            chk("R7 not rearmed", 32'(status[2]), 32'h0);
            rd_n(1); land_n(1); settle();
            chk("R7 rearmed", 32'(status[2]), 32'h1);
            disable_ch(); clear_all();
        end
        rx_fifo_en = 1'b0;

        // R8 word count sweep
        tx_fifo_en = 1'b1;
        ae_level = CW'(1);
        for (int wc = 0; wc <= 5; wc++) begin
            word_count = WCW'(wc);
            enable_ch(); clear_all();
            if (wc == 0) begin
                load_n(6); settle();
                chk("R8 zero count eow", 32'(status[3]), 32'h0);
                chk("R8 zero count halt", 32'(halt), 32'h0);
            end else begin
                load_n(wc - 1); settle();
                chk("R8 before count", 32'({status[3], halt}), 32'h0);
                load_n(1); settle();
                chk("R8 at count", 32'({status[3], halt}), 32'h3);
                load_n(2); settle();
                chk("R8 halt held", 32'(halt), 32'h1);
            end
            disable_ch();
            chk("R8 halt released", 32'(halt), 32'h0);
            clear_all();
        end

        // R9 FIFO bypass
        other_fifo_req = 1'b1;
        rx_fifo_en = 1'b1;
        af_level = CW'(3);
        word_count = WCW'(2);
        enable_ch(); clear_all();
        load_n(3); settle();
        chk("R9 no eow when bypassed", 32'({status[3], halt}), 32'h0);
        land_n(1); settle();
        chk("R9 rx register mode", 32'(status[2]), 32'h1);
        disable_ch(); clear_all();

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule